// File: doc/BRIEF.md
# Dirty Band Refresh Tracker

This block tells a display refresh engine which parts of the frame store changed since the last refresh. The frame is split into bands of four scanlines, and the block holds one dirty bit per band. Writes to any of the memory planes behind a band set that band's bit. In 8-bit mode only the index plane counts. In 24-bit mode the direct-colour plane and the per-pixel control plane count as well. Each of those planes has four pages per band. A full-invalidate input marks every band dirty at once.

A refresh pass starts with a one-cycle start pulse. It walks the bands from the top of the frame to the configured height, one band per clock. For each dirty band it raises a one-cycle redraw strobe carrying the band's first line. Runs of consecutive dirty bands are merged into one update region, given as a start line and a line count. A region is emitted when the first clean band follows it, or at the end of the pass. The pass then clears the dirty bits from the lowest to the highest dirty band it met. The pixel drawing itself is done elsewhere.

Top module: `dbt_refresh_tracker`

## Requirements
- R1: A band covers four lines. For every dirty band visited, the block raises `redraw_valid` for exactly one cycle with `redraw_line` equal to four times the band number. Strobes come in ascending band order.
- R2: A run of consecutive dirty bands yields a single update. Its `upd_start` is the first line of the run's first band. The update is emitted when a clean band is visited, with `upd_count` equal to that clean band's first line minus `upd_start`.
- R3: A region still open when the scan stops is emitted at the end of the pass. Its count is four times the number of visited bands, minus the start. The visited bands are ceil(height/4), capped at the band count, so the count may run past a height that is not a multiple of four.
- R4: After a pass, every band from the lowest to the highest dirty band visited is clean. Bands at or beyond the height keep their bits. A pass that met no dirty band clears nothing.
- R5: An index-plane write to page p sets band p. A direct-plane or control-plane write to page q sets band q>>2, but only while `mode_24` is 1; in 8-bit mode such writes have no effect. A page whose band is not below the band count has no effect.
- R6: A one-cycle `invalidate` sets every band dirty.
- R7: A `start_pass` while `pix_depth` is zero is ignored. No pass starts, no strobe or update appears, and all dirty bits are kept.
- R8: A write that sets a bit in the same cycle that the end-of-pass clear removes it leaves the bit set.
- R9: After reset all bands are clean, the block is idle, and every output strobe is low.
- R10: `busy` is high from the cycle after an accepted start until the end of the pass. `pass_done` is high for exactly one cycle, the last busy cycle. The block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_24 | input | 1 | 1: direct-colour and control plane writes mark bands |
| pix_depth | input | 6 | Output pixel depth in bits; zero suppresses passes |
| frame_height | input | LINE_W | Frame height in lines |
| start_pass | input | 1 | One-cycle request to start a refresh pass |
| invalidate | input | 1 | Mark every band dirty |
| wr8_valid | input | 1 | Index-plane write strobe |
| wr8_page | input | BAND_W | Index-plane page written (one page per band) |
| wr24_valid | input | 1 | Direct-colour plane write strobe |
| wr24_page | input | BAND_W+2 | Direct-colour plane page (four pages per band) |
| wrc_valid | input | 1 | Control plane write strobe |
| wrc_page | input | BAND_W+2 | Control plane page (four pages per band) |
| busy | output | 1 | Pass in progress |
| pass_done | output | 1 | Last cycle of a pass |
| redraw_valid | output | 1 | Band redraw strobe |
| redraw_line | output | LINE_W | First line of the band to redraw |
| upd_valid | output | 1 | Update region strobe |
| upd_start | output | LINE_W | First line of the update region |
| upd_count | output | LINE_W | Line count of the update region |

## Verification
The bench builds the block with a 60-line maximum, which gives 15 bands. That small size lets a 16-bit pattern generator cover dense, sparse and alternating dirty maps over hundreds of passes. Heights of 0, 1, 4, 10, 17, 33, 48, 60 and 63 reach the empty scan, partial last bands and the cap at the band count. The 4-bit index page also reaches the one out-of-range band value. A reference model of the dirty map predicts the order of every strobe and region. It also carries the map from pass to pass, so clearing errors show up in the next pass.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  localparam int LINES_PER_BAND = 4;
  localparam int BAND_SHIFT     = 2;
  localparam int NUM_PLANES     = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_CLEAR = 2'd3
  } scan_state_e;

endpackage

// File: rtl/dbt_page_decode.sv
module dbt_page_decode #(
  parameter int NUM_BANDS = 192,
  parameter int IDX_W     = 10,
  parameter int SHIFT     = 0
) (
  input  logic                 valid,
  input  logic                 enable,
  input  logic [IDX_W-1:0]     page,
  output logic [NUM_BANDS-1:0] band_mask
);

  logic [IDX_W-1:0] band;

  assign band = page >> SHIFT;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign band_mask[b] = valid & enable & (band == IDX_W'(b));
  end

  always_comb begin
    assert ($countones(band_mask) <= 1)
      else $error("assert_one_band_per_write_R5");
  end

endmodule

// File: rtl/dbt_dirty_store.sv
module dbt_dirty_store #(
  parameter int NUM_BANDS = 192,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANDS-1:0] set_mask,
  input  logic                 invalidate,
  input  logic                 clr_en,
  input  logic [CNT_W-1:0]     clr_lo,
  input  logic [CNT_W-1:0]     clr_hi,
  input  logic [CNT_W-1:0]     rd_idx,
  output logic                 rd_dirty
);

  logic [NUM_BANDS-1:0] dirty_q;
  logic [NUM_BANDS-1:0] dirty_d;
  logic [NUM_BANDS-1:0] set_all;
  logic [NUM_BANDS-1:0] clr_mask;
  logic [NUM_BANDS-1:0] rd_hit;
  logic                 upd_en;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign clr_mask[b] = clr_en && (clr_lo <= CNT_W'(b)) && (CNT_W'(b) <= clr_hi);
    assign rd_hit[b]   = dirty_q[b] && (rd_idx == CNT_W'(b));
  end

  assign set_all  = set_mask | {NUM_BANDS{invalidate}};
  assign rd_dirty = |rd_hit;
  assign upd_en   = clr_en | (|set_all);

  // set is applied after clear so a simultaneous write survives
  always_comb begin
    dirty_d = (dirty_q & ~clr_mask) | set_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= '0;
    end else if (upd_en) begin
      dirty_q <= dirty_d;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ((dirty_q & $past(set_all)) == $past(set_all)));

  assert_clear_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en) |=> ((~dirty_q & $past(dirty_q)) == '0));

  assert_invalidate_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> (&dirty_q));

endmodule

// File: rtl/dbt_scan_ctrl.sv
module dbt_scan_ctrl
  import dbt_pkg::*;
#(
  parameter int NUM_BANDS = 192,
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pass,
  input  logic              depth_nz,
  input  logic [LINE_W-1:0] height,
  input  logic              rd_dirty,
  output logic [CNT_W-1:0]  rd_idx,
  output logic              clr_en,
  output logic [CNT_W-1:0]  clr_lo,
  output logic [CNT_W-1:0]  clr_hi,
  output logic              busy,
  output logic              pass_done,
  output logic              redraw_valid,
  output logic [LINE_W-1:0] redraw_line,
  output logic              upd_valid,
  output logic [LINE_W-1:0] upd_start,
  output logic [LINE_W-1:0] upd_count
);

  scan_state_e       state_q, state_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              open_q, open_d;
  logic [LINE_W-1:0] start_q, start_d;
  logic [CNT_W-1:0]  lo_q, lo_d;
  logic [CNT_W-1:0]  hi_q, hi_d;
  logic              any_q, any_d;
  logic              rdv_q, rdv_d;
  logic [LINE_W-1:0] rdl_q, rdl_d;
  logic              updv_q, updv_d;
  logic [LINE_W-1:0] upds_q, upds_d;
  logic [LINE_W-1:0] updc_q, updc_d;

  logic [LINE_W-1:0] scan_line;
  logic              in_range;

  assign scan_line = {idx_q, 2'b00};
  assign in_range  = (idx_q < CNT_W'(NUM_BANDS)) && (scan_line < height);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    open_d  = open_q;
    start_d = start_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    any_d   = any_q;
    rdv_d   = 1'b0;
    rdl_d   = rdl_q;
    updv_d  = 1'b0;
    upds_d  = upds_q;
    updc_d  = updc_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_pass && depth_nz) begin
          state_d = ST_SCAN;
          idx_d   = '0;
          open_d  = 1'b0;
          any_d   = 1'b0;
          lo_d    = '0;
          hi_d    = '0;
        end
      end
      ST_SCAN: begin
        if (in_range) begin
          idx_d = idx_q + 1'b1;
          if (rd_dirty) begin
            rdv_d = 1'b1;
            rdl_d = scan_line;
            if (!open_q) begin
              open_d  = 1'b1;
              start_d = scan_line;
            end
            if (!any_q) begin
              lo_d = idx_q;
            end
            hi_d  = idx_q;
            any_d = 1'b1;
          end else if (open_q) begin
            updv_d = 1'b1;
            upds_d = start_q;
            updc_d = scan_line - start_q;
            open_d = 1'b0;
          end
        end else begin
          state_d = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (open_q) begin
          updv_d = 1'b1;
          upds_d = start_q;
          updc_d = scan_line - start_q;
          open_d = 1'b0;
        end
        state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      open_q  <= 1'b0;
      start_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      any_q   <= 1'b0;
      rdv_q   <= 1'b0;
      rdl_q   <= '0;
      updv_q  <= 1'b0;
      upds_q  <= '0;
      updc_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      open_q  <= open_d;
      start_q <= start_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      any_q   <= any_d;
      rdv_q   <= rdv_d;
      rdl_q   <= rdl_d;
      updv_q  <= updv_d;
      upds_q  <= upds_d;
      updc_q  <= updc_d;
    end
  end

  assign rd_idx       = idx_q;
  assign clr_en       = (state_q == ST_CLEAR) && any_q;
  assign clr_lo       = lo_q;
  assign clr_hi       = hi_q;
  assign busy         = (state_q != ST_IDLE);
  assign pass_done    = (state_q == ST_CLEAR);
  assign redraw_valid = rdv_q;
  assign redraw_line  = rdl_q;
  assign upd_valid    = updv_q;
  assign upd_start    = upds_q;
  assign upd_count    = updc_q;

  assert_redraw_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    redraw_valid |-> (redraw_line[1:0] == 2'b00 && busy));

  assert_region_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_count != '0 && upd_count[1:0] == 2'b00 && busy));

  assert_depth_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_pass && !depth_nz) |=> !busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> (!pass_done && !busy));

  assert_clear_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (clr_lo <= clr_hi));

endmodule

// File: rtl/dbt_refresh_tracker.sv
module dbt_refresh_tracker
  import dbt_pkg::*;
#(
  parameter int MAX_LINES = 768,
  localparam int NUM_BANDS = (MAX_LINES + LINES_PER_BAND - 1) / LINES_PER_BAND,
  localparam int BAND_W    = $clog2(NUM_BANDS),
  localparam int CNT_W     = $clog2(NUM_BANDS + 1),
  localparam int LINE_W    = CNT_W + BAND_SHIFT,
  localparam int PAGE24_W  = BAND_W + BAND_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_24,
  input  logic [5:0]          pix_depth,
  input  logic [LINE_W-1:0]   frame_height,
  input  logic                start_pass,
  input  logic                invalidate,
  input  logic                wr8_valid,
  input  logic [BAND_W-1:0]   wr8_page,
  input  logic                wr24_valid,
  input  logic [PAGE24_W-1:0] wr24_page,
  input  logic                wrc_valid,
  input  logic [PAGE24_W-1:0] wrc_page,
  output logic                busy,
  output logic                pass_done,
  output logic                redraw_valid,
  output logic [LINE_W-1:0]   redraw_line,
  output logic                upd_valid,
  output logic [LINE_W-1:0]   upd_start,
  output logic [LINE_W-1:0]   upd_count
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_PLANES-1:0] pl_valid;
  logic [NUM_PLANES-1:0] pl_en;
  logic [PAGE24_W-1:0]   pl_page [NUM_PLANES];
  logic [NUM_BANDS-1:0]  pl_mask [NUM_PLANES];
  logic [NUM_BANDS-1:0]  set_mask;

  assign pl_valid   = {wrc_valid, wr24_valid, wr8_valid};
  assign pl_en      = {mode_24, mode_24, 1'b1};
  assign pl_page[0] = PAGE24_W'(wr8_page);
  assign pl_page[1] = wr24_page;
  assign pl_page[2] = wrc_page;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    dbt_page_decode #(
      .NUM_BANDS (NUM_BANDS),
      .IDX_W     (PAGE24_W),
      .SHIFT     ((p == 0) ? 0 : BAND_SHIFT)
    ) u_dec (
      .valid     (pl_valid[p]),
      .enable    (pl_en[p]),
      .page      (pl_page[p]),
      .band_mask (pl_mask[p])
    );
  end

  always_comb begin
    set_mask = '0;
    for (int p = 0; p < NUM_PLANES; p++) begin
      set_mask = set_mask | pl_mask[p];
    end
  end

  logic [CNT_W-1:0] rd_idx;
  logic             rd_dirty;
  logic             clr_en;
  logic [CNT_W-1:0] clr_lo;
  logic [CNT_W-1:0] clr_hi;

  dbt_dirty_store #(
    .NUM_BANDS (NUM_BANDS),
    .CNT_W     (CNT_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_mask   (set_mask),
    .invalidate (invalidate),
    .clr_en     (clr_en),
    .clr_lo     (clr_lo),
    .clr_hi     (clr_hi),
    .rd_idx     (rd_idx),
    .rd_dirty   (rd_dirty)
  );

  dbt_scan_ctrl #(
    .NUM_BANDS (NUM_BANDS),
    .CNT_W     (CNT_W),
    .LINE_W    (LINE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_pass   (start_pass),
    .depth_nz     (|pix_depth),
    .height       (frame_height),
    .rd_dirty     (rd_dirty),
    .rd_idx       (rd_idx),
    .clr_en       (clr_en),
    .clr_lo       (clr_lo),
    .clr_hi       (clr_hi),
    .busy         (busy),
    .pass_done    (pass_done),
    .redraw_valid (redraw_valid),
    .redraw_line  (redraw_line),
    .upd_valid    (upd_valid),
    .upd_start    (upd_start),
    .upd_count    (upd_count)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    (!rst_int_n) |-> (!busy && !redraw_valid && !upd_valid));

endmodule

// File: tb/dbt_refresh_tracker_tb.sv
module dbt_refresh_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_LINES  = 60;
  localparam int NB         = 15;
  localparam int LINE_W     = 6;
  localparam int BAND_W     = 4;
  localparam int PAGE_W     = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mode_24;
  logic [5:0]        pix_depth;
  logic [LINE_W-1:0] frame_height;
  logic              start_pass;
  logic              invalidate;
  logic              wr8_valid;
  logic [BAND_W-1:0] wr8_page;
  logic              wr24_valid;
  logic [PAGE_W-1:0] wr24_page;
  logic              wrc_valid;
  logic [PAGE_W-1:0] wrc_page;
  logic              busy, pass_done, redraw_valid, upd_valid;
  logic [LINE_W-1:0] redraw_line, upd_start, upd_count;

  dbt_refresh_tracker #(.MAX_LINES(MAX_LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_24(mode_24), .pix_depth(pix_depth),
    .frame_height(frame_height), .start_pass(start_pass), .invalidate(invalidate),
    .wr8_valid(wr8_valid), .wr8_page(wr8_page),
    .wr24_valid(wr24_valid), .wr24_page(wr24_page),
    .wrc_valid(wrc_valid), .wrc_page(wrc_page),
    .busy(busy), .pass_done(pass_done),
    .redraw_valid(redraw_valid), .redraw_line(redraw_line),
    .upd_valid(upd_valid), .upd_start(upd_start), .upd_count(upd_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] mdirty;

  int    exp_t [64];
  int    exp_a [64];
  int    exp_b [64];
  string exp_r [64];
  int    exp_n;
  int    got_t [64];
  int    got_a [64];
  int    got_b [64];
  int    got_n;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_wr8(input int page);
    @(negedge clk);
    wr8_valid = 1'b1;
    wr8_page  = page[BAND_W-1:0];
    @(negedge clk);
    wr8_valid = 1'b0;
    if (page < NB) mdirty[page] = 1'b1;
  endtask

  task automatic do_wrp(input int page, input bit ctl);
    @(negedge clk);
    if (ctl) begin wrc_valid = 1'b1; wrc_page = page[PAGE_W-1:0]; end
    else begin wr24_valid = 1'b1; wr24_page = page[PAGE_W-1:0]; end
    @(negedge clk);
    wrc_valid  = 1'b0;
    wr24_valid = 1'b0;
    if (mode_24 && (page / 4) < NB) mdirty[page / 4] = 1'b1;
  endtask

  task automatic do_inval();
    @(negedge clk);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    mdirty = '1;
  endtask

  task automatic add_exp(input int t, input int a, input int b, input string r);
    exp_t[exp_n] = t; exp_a[exp_n] = a; exp_b[exp_n] = b; exp_r[exp_n] = r;
    exp_n++;
  endtask

  task automatic run_pass(input int h, input string tag, input int collide);
    int  visited;
    int  lo;
    int  hi;
    int  st;
    bit  open;
    bit  busy_bad;
    int  cyc;
    exp_n = 0;
    got_n = 0;
    visited = (h + 3) / 4;
    if (visited > NB) visited = NB;
    lo = -1; hi = -1; open = 1'b0; st = 0;
    for (int b = 0; b < visited; b++) begin
      if (mdirty[b]) begin
        add_exp(1, b * 4, 0, "R1");
        if (!open) begin open = 1'b1; st = b * 4; end
        if (lo < 0) lo = b;
        hi = b;
      end else if (open) begin
        add_exp(2, st, b * 4 - st, "R2");
        open = 1'b0;
      end
    end
    if (open) add_exp(2, st, visited * 4 - st, "R3");

    @(negedge clk);
    frame_height = h[LINE_W-1:0];
    start_pass   = 1'b1;
    @(negedge clk);
    start_pass = 1'b0;
    busy_bad = 1'b0;
    cyc = 0;
    while (1) begin
      if (redraw_valid && got_n < 64) begin
        got_t[got_n] = 1; got_a[got_n] = int'(redraw_line); got_b[got_n] = 0; got_n++;
      end
      if (upd_valid && got_n < 64) begin
        got_t[got_n] = 2; got_a[got_n] = int'(upd_start); got_b[got_n] = int'(upd_count); got_n++;
      end
      if (!busy) busy_bad = 1'b1;
      if (pass_done) break;
      cyc++;
      if (cyc > 100) break;
      @(negedge clk);
    end
    check(pass_done == 1'b1, "R10", {tag, " pass_done reached"}, int'(pass_done), 1);
    check(!busy_bad, "R10", {tag, " busy through pass"}, int'(busy_bad), 0);
    if (collide >= 0) begin
      wr8_valid = 1'b1;
      wr8_page  = collide[BAND_W-1:0];
    end
    @(negedge clk);
    wr8_valid = 1'b0;
    check(!busy && !pass_done, "R10", {tag, " idle after done"}, int'(busy), 0);
    if (lo >= 0) begin
      for (int b = lo; b <= hi; b++) mdirty[b] = 1'b0;
    end
    if (collide >= 0 && collide < NB) mdirty[collide] = 1'b1;

    check(got_n == exp_n, tag, "event count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_t[i] == exp_t[i], exp_r[i], {tag, " event kind"}, got_t[i], exp_t[i]);
      check(got_a[i] == exp_a[i], exp_r[i], {tag, " event line"}, got_a[i], exp_a[i]);
      check(got_b[i] == exp_b[i], exp_r[i], {tag, " event count"}, got_b[i], exp_b[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int heights [8];
    heights = '{60, 63, 0, 1, 4, 17, 33, 48};
    rst_n = 1'b0; mode_24 = 1'b0; pix_depth = 6'd32; frame_height = '0;
    start_pass = 1'b0; invalidate = 1'b0;
    wr8_valid = 1'b0; wr8_page = '0; wr24_valid = 1'b0; wr24_page = '0;
    wrc_valid = 1'b0; wrc_page = '0;
    mdirty = '0;
    repeat (3) @(negedge clk);
    check(!busy && !redraw_valid && !upd_valid && !pass_done, "R9", "reset outputs",
          int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_pass(60, "R9", -1);
    do_wr8(0);
    run_pass(60, "R1", -1);
    do_wr8(14);
    run_pass(60, "R3", -1);
    do_wr8(3); do_wr8(4); do_wr8(5); do_wr8(9);
    run_pass(60, "R2", -1);
    do_wr8(2);
    run_pass(10, "R3", -1);
    do_wr8(5);
    run_pass(10, "R4", -1);
    run_pass(60, "R4", -1);
    do_wr8(15);
    run_pass(63, "R5", -1);
    do_wrp(8, 1'b1); do_wrp(20, 1'b0);
    run_pass(63, "R5", -1);
    mode_24 = 1'b1;
    do_wrp(8, 1'b0); do_wrp(27, 1'b1); do_wrp(63, 1'b0);
    run_pass(63, "R5", -1);
    do_inval();
    run_pass(63, "R6", -1);
    do_wr8(4); do_wr8(7);
    run_pass(60, "R8", 5);
    run_pass(60, "R8", -1);

    do_wr8(1);
    pix_depth = 6'd0;
    @(negedge clk);
    start_pass = 1'b1;
    @(negedge clk);
    start_pass = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(!busy && !redraw_valid && !upd_valid, "R7", "depth zero quiet",
            int'(busy), 0);
      @(negedge clk);
    end
    pix_depth = 6'd16;
    run_pass(60, "R7", -1);

    lfsr = 16'hACE1;
    for (int it = 0; it < 250; it++) begin
      for (int k = 0; k < 5; k++)
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mode_24 = lfsr[15];
      for (int b = 0; b < NB; b++) begin
        if (lfsr[b]) begin
          if (mode_24 && (b % 2 == 1)) do_wrp(b * 4 + (it % 4), it[0]);
          else do_wr8(b);
        end
      end
      run_pass(heights[it % 8], "R2", -1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule